// File: doc/BRIEF.md
# Multi-Issue Reorder Buffer

This block is the in-order retirement queue of a speculative out-of-order core. The front end allocates up to three micro-operations per cycle, in program order, into a 40-slot circular buffer. Each slot is named by a tag, which is its position in the ring. Execution units report results out of order on five completion ports. Each report carries a tag, a result value, an exception flag and a mispredict flag. The oldest finished slots retire in program order, up to three per cycle, towards the architectural register file.

Operand lookup ports let a consumer find the value of an architectural register that is still held in the buffer. A lookup names the register and the requester's own tag. It returns the youngest producer that is older than the requester: the producer's tag, and its value once that value is ready. When a lookup misses, the consumer reads the register file.

A completion marked mispredicted or faulting discards every younger slot in the same cycle and moves the allocation point to the slot just after it. A mispredicted branch then retires normally. A faulting operation is never retired. When it reaches the retirement window, the buffer reports its tag and empties itself.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `alloc_tag` is 0, and no commit, exception report or lookup hit is present. Tags are 0 to 39, handed out consecutively, and wrap from 39 to 0.
- R2: A granted request of `alloc_cnt` = n (0 to 3) takes the tags `alloc_tag` to `alloc_tag`+n-1. Lane k of `alloc_dst` (bits 5k+4:5k) is the destination of tag `alloc_tag`+k. `alloc_tag` advances by n on the next cycle.
- R3: `alloc_ok` is 0, and nothing is taken, when `alloc_cnt` exceeds the free slots, in a cycle with a flushing completion, and in a cycle with an exception report.
- R4: All five completion ports may report in the same cycle. Every valid report marks its slot finished and stores its value.
- R5: Commit lanes 0..2 carry the oldest slots in program order, and the valid lanes are contiguous from lane 0. Commit stops at the first unfinished slot. A slot completed at clock edge N is offered at the earliest in the cycle after edge N.
- R6: A lookup returns the youngest buffered slot that is older than `rd_tag` and has the requested destination. `rd_src` gives that slot's tag. `rd_ready`/`rd_data` are valid once that slot has finished. With no such slot, `rd_hit` is 0.
- R7: A completion with the mispredict flag at tag T discards all slots younger than T, and `alloc_tag` becomes T+1 on the next cycle. Slot T itself commits.
- R8: A completion with the exception flag at tag T discards younger slots in the same way. Slot T is never committed. When T is the first unretired slot within the commit window, `exc_vld` pulses with `exc_tag` = T, the older slots in the window commit, and the buffer empties, with `alloc_tag` = T+1.
- R9: When several flushing completions arrive in one cycle, the one oldest in program order sets the new allocation point.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt | input | 2 | Number of slots requested this cycle |
| alloc_dst | input | 15 | Destination registers, 5 bits per lane |
| alloc_ok | output | 1 | Request granted |
| alloc_tag | output | 6 | Tag of lane 0 of the allocation |
| cpl_vld | input | 5 | Completion port valid |
| cpl_tag | input | 30 | Completion tags, 6 bits per port |
| cpl_data | input | 160 | Completion results, 32 bits per port |
| cpl_exc | input | 5 | Completion raised an exception |
| cpl_mispred | input | 5 | Completion is a mispredicted branch |
| rd_areg | input | 10 | Lookup register, 5 bits per lookup port |
| rd_tag | input | 12 | Requester tag, 6 bits per lookup port |
| rd_hit | output | 2 | A buffered producer exists |
| rd_ready | output | 2 | The producer's value is ready |
| rd_data | output | 64 | Producer value, 32 bits per lookup port |
| rd_src | output | 12 | Producer tag, 6 bits per lookup port |
| cmt_vld | output | 3 | Commit lane valid |
| cmt_dst | output | 15 | Committed destination, 5 bits per lane |
| cmt_data | output | 96 | Committed value, 32 bits per lane |
| exc_vld | output | 1 | Faulting slot reached retirement |
| exc_tag | output | 6 | Tag of the faulting slot |

## Verification
Completions are driven in reverse and scattered order, so a commit stream that matches program order shows real reordering rather than a pass-through of completion order. The stream is further exercised with five simultaneous reports that leave the oldest slot pending, which tells a commit stop at a gap apart from a plain width limit. Lookups with repeated destinations and different requester tags separate "youngest older producer" from "any match" and from "first match". A full fill that wraps past tag 39 tells the free-slot stall apart from a pointer-compare bug. Mispredict, exception and double-flush cases check that discarded slots never appear at the commit ports, and that the oldest flush decides the new tail.

// File: rtl/rob_pkg.sv
package rob_pkg;
   // modular sum of two ring positions; b must be smaller than depth
   function automatic int ring_add(input int a, input int b, input int depth);
      int s;
      s = a + b;
      if (s >= depth) s = s - depth;
      return s;
   endfunction

   // distance travelled from position 'from' forward to position 'to'
   function automatic int ring_dist(input int from, input int to, input int depth);
      return (to >= from) ? (to - from) : (to + depth - from);
   endfunction
endpackage

// File: rtl/rob_alloc_ctl.sv
module rob_alloc_ctl #(
   parameter int DEPTH   = 40,
   parameter int ALLOC_W = 3,
   parameter int CNT_W   = 6,
   parameter int AC_W    = 2
) (
   input  logic [CNT_W-1:0] count,
   input  logic [AC_W-1:0]  req_cnt,
   input  logic             block,
   output logic             grant,
   output logic [AC_W-1:0]  n_take
);
   int free_slots;

   always_comb begin
      free_slots = DEPTH - int'(count);
      grant      = !block && (int'(req_cnt) <= ALLOC_W) && (int'(req_cnt) <= free_slots);
      n_take     = grant ? req_cnt : '0;
   end
endmodule

// File: rtl/rob_flush_pick.sv
module rob_flush_pick import rob_pkg::*; #(
   parameter int DEPTH = 40,
   parameter int CPL_N = 5,
   parameter int TAG_W = 6
) (
   input  logic [TAG_W-1:0]       head,
   input  logic [CPL_N-1:0]       req,
   input  logic [CPL_N*TAG_W-1:0] tags,
   output logic                   flush,
   output logic [TAG_W-1:0]       flush_tag,
   output logic [TAG_W-1:0]       flush_age
);
   int best;

   always_comb begin
      best      = DEPTH;
      flush_tag = '0;
      for (int p = 0; p < CPL_N; p++) begin
         int rel;
         rel = ring_dist(int'(head), int'(tags[p*TAG_W +: TAG_W]), DEPTH);
         if (req[p] && rel < best) begin
            best      = rel;
            flush_tag = tags[p*TAG_W +: TAG_W];
         end
      end
      flush     = (best < DEPTH);
      flush_age = flush ? TAG_W'(best) : '0;
   end
endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel #(
   parameter int COMMIT_W = 3,
   parameter int NC_W     = 2,
   parameter int LANE_W   = 2
) (
   input  logic [COMMIT_W-1:0] win_vld,
   input  logic [COMMIT_W-1:0] win_done,
   input  logic [COMMIT_W-1:0] win_exc,
   output logic [COMMIT_W-1:0] take,
   output logic [NC_W-1:0]     n_take,
   output logic                fault,
   output logic [LANE_W-1:0]   fault_lane
);
   always_comb begin
      logic stop;
      stop       = 1'b0;
      take       = '0;
      n_take     = '0;
      fault      = 1'b0;
      fault_lane = '0;
      for (int j = 0; j < COMMIT_W; j++) begin
         if (!stop) begin
            if (win_vld[j] && win_done[j] && !win_exc[j]) begin
               take[j] = 1'b1;
               n_take  = n_take + 1'b1;
            end else begin
               if (win_vld[j] && win_done[j]) begin
                  fault      = 1'b1;
                  fault_lane = LANE_W'(j);
               end
               stop = 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/rob_fwd_port.sv
module rob_fwd_port import rob_pkg::*; #(
   parameter int DEPTH  = 40,
   parameter int TAG_W  = 6,
   parameter int AREG_W = 5,
   parameter int DATA_W = 32
) (
   input  logic [TAG_W-1:0]        head,
   input  logic [DEPTH-1:0]        vld,
   input  logic [DEPTH-1:0]        done,
   input  logic [DEPTH*AREG_W-1:0] dst_flat,
   input  logic [DEPTH*DATA_W-1:0] data_flat,
   input  logic [AREG_W-1:0]       areg,
   input  logic [TAG_W-1:0]        req_tag,
   output logic                    hit,
   output logic                    ready,
   output logic [DATA_W-1:0]       data,
   output logic [TAG_W-1:0]        src
);
   int req_rel;
   int best_rel;
   int best_idx;

   always_comb begin
      req_rel  = ring_dist(int'(head), int'(req_tag), DEPTH);
      best_rel = -1;
      best_idx = 0;
      for (int i = 0; i < DEPTH; i++) begin
         int rel;
         rel = ring_dist(int'(head), i, DEPTH);
         if (vld[i] && dst_flat[i*AREG_W +: AREG_W] == areg &&
             rel < req_rel && rel > best_rel) begin
            best_rel = rel;
            best_idx = i;
         end
      end
      hit   = (best_rel >= 0);
      ready = hit && done[best_idx];
      data  = ready ? data_flat[best_idx*DATA_W +: DATA_W] : '0;
      src   = hit ? TAG_W'(best_idx) : '0;
   end
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf import rob_pkg::*; #(
   parameter int DEPTH    = 40,
   parameter int ALLOC_W  = 3,
   parameter int COMMIT_W = 3,
   parameter int CPL_N    = 5,
   parameter int RD_N     = 2,
   parameter int DATA_W   = 32,
   parameter int AREG_W   = 5,
   localparam int TAG_W   = $clog2(DEPTH),
   localparam int AC_W    = $clog2(ALLOC_W + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [AC_W-1:0]            alloc_cnt,
   input  logic [ALLOC_W*AREG_W-1:0]  alloc_dst,
   output logic                       alloc_ok,
   output logic [TAG_W-1:0]           alloc_tag,
   input  logic [CPL_N-1:0]           cpl_vld,
   input  logic [CPL_N*TAG_W-1:0]     cpl_tag,
   input  logic [CPL_N*DATA_W-1:0]    cpl_data,
   input  logic [CPL_N-1:0]           cpl_exc,
   input  logic [CPL_N-1:0]           cpl_mispred,
   input  logic [RD_N*AREG_W-1:0]     rd_areg,
   input  logic [RD_N*TAG_W-1:0]      rd_tag,
   output logic [RD_N-1:0]            rd_hit,
   output logic [RD_N-1:0]            rd_ready,
   output logic [RD_N*DATA_W-1:0]     rd_data,
   output logic [RD_N*TAG_W-1:0]      rd_src,
   output logic [COMMIT_W-1:0]        cmt_vld,
   output logic [COMMIT_W*AREG_W-1:0] cmt_dst,
   output logic [COMMIT_W*DATA_W-1:0] cmt_data,
   output logic                       exc_vld,
   output logic [TAG_W-1:0]           exc_tag
);
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int NC_W   = $clog2(COMMIT_W + 1);
   localparam int LANE_W = (COMMIT_W > 1) ? $clog2(COMMIT_W) : 1;

   initial begin
      assert (DEPTH >= 4) else $error("reorder_buf: DEPTH too small");
      assert (ALLOC_W >= 1 && ALLOC_W < DEPTH) else $error("reorder_buf: bad ALLOC_W");
      assert (COMMIT_W >= 1 && COMMIT_W < DEPTH) else $error("reorder_buf: bad COMMIT_W");
      assert (CPL_N >= 1 && RD_N >= 1) else $error("reorder_buf: need ports");
   end

   // ---------------- state ----------------
   logic [TAG_W-1:0]  head_q, tail_q;
   logic [CNT_W-1:0]  count_q;
   logic [DEPTH-1:0]  vld_q, done_q, exc_q;
   logic [AREG_W-1:0] dst_q  [DEPTH];
   logic [DATA_W-1:0] data_q [DEPTH];

   logic [DEPTH*AREG_W-1:0] dst_flat;
   logic [DEPTH*DATA_W-1:0] data_flat;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         dst_flat[i*AREG_W +: AREG_W]  = dst_q[i];
         data_flat[i*DATA_W +: DATA_W] = data_q[i];
      end
   end

   // ---------------- flush selection ----------------
   logic [CPL_N-1:0] fl_req;
   logic             flush;
   logic [TAG_W-1:0] flush_tag, flush_age;

   always_comb begin
      for (int p = 0; p < CPL_N; p++)
         fl_req[p] = cpl_vld[p] && (cpl_exc[p] || cpl_mispred[p]) &&
                     vld_q[cpl_tag[p*TAG_W +: TAG_W]];
   end

   rob_flush_pick #(.DEPTH(DEPTH), .CPL_N(CPL_N), .TAG_W(TAG_W)) u_flush (
      .head(head_q), .req(fl_req), .tags(cpl_tag),
      .flush(flush), .flush_tag(flush_tag), .flush_age(flush_age)
   );

   // ---------------- commit window ----------------
   logic [TAG_W-1:0]    widx [COMMIT_W];
   logic [COMMIT_W-1:0] win_vld, win_done, win_exc, take;
   logic [NC_W-1:0]     n_cmt;
   logic                fault;
   logic [LANE_W-1:0]   fault_lane;

   always_comb begin
      for (int j = 0; j < COMMIT_W; j++) begin
         widx[j]     = TAG_W'(ring_add(int'(head_q), j, DEPTH));
         win_vld[j]  = (j < int'(count_q)) && vld_q[widx[j]];
         win_done[j] = done_q[widx[j]];
         win_exc[j]  = exc_q[widx[j]];
         cmt_dst[j*AREG_W +: AREG_W]  = dst_q[widx[j]];
         cmt_data[j*DATA_W +: DATA_W] = data_q[widx[j]];
      end
   end

   rob_commit_sel #(.COMMIT_W(COMMIT_W), .NC_W(NC_W), .LANE_W(LANE_W)) u_commit (
      .win_vld(win_vld), .win_done(win_done), .win_exc(win_exc),
      .take(take), .n_take(n_cmt), .fault(fault), .fault_lane(fault_lane)
   );

   assign cmt_vld = take;
   assign exc_vld = fault;
   assign exc_tag = fault ? widx[fault_lane] : '0;

   // ---------------- allocation ----------------
   logic [AC_W-1:0] n_alloc;

   rob_alloc_ctl #(.DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .CNT_W(CNT_W), .AC_W(AC_W)) u_alloc (
      .count(count_q), .req_cnt(alloc_cnt), .block(flush || fault),
      .grant(alloc_ok), .n_take(n_alloc)
   );

   assign alloc_tag = tail_q;

   // ---------------- next state ----------------
   int               n_ret;
   logic [DEPTH-1:0] vld_n, done_n, exc_n, take_alloc;
   int               alloc_lane [DEPTH];
   logic [TAG_W-1:0] head_n, tail_n;
   logic [CNT_W-1:0] count_n;

   always_comb begin
      n_ret = int'(n_cmt) + (fault ? 1 : 0);
      for (int i = 0; i < DEPTH; i++) begin
         int  rel, arel;
         logic kill, leave;
         rel           = ring_dist(int'(head_q), i, DEPTH);
         arel          = ring_dist(int'(tail_q), i, DEPTH);
         take_alloc[i] = arel < int'(n_alloc);
         alloc_lane[i] = take_alloc[i] ? arel : 0;
         kill          = fault || (flush && rel > int'(flush_age));
         leave         = rel < n_ret;
         vld_n[i]      = take_alloc[i] || (vld_q[i] && !kill && !leave);
         done_n[i]     = take_alloc[i] ? 1'b0 : done_q[i];
         exc_n[i]      = take_alloc[i] ? 1'b0 : exc_q[i];
         for (int p = 0; p < CPL_N; p++) begin
            if (cpl_vld[p] && int'(cpl_tag[p*TAG_W +: TAG_W]) == i && vld_q[i]) begin
               done_n[i] = 1'b1;
               exc_n[i]  = exc_n[i] | cpl_exc[p];
            end
         end
      end

      if (fault) begin
         head_n  = TAG_W'(ring_add(int'(exc_tag), 1, DEPTH));
         tail_n  = head_n;
         count_n = '0;
      end else if (flush) begin
         head_n  = TAG_W'(ring_add(int'(head_q), n_ret, DEPTH));
         tail_n  = TAG_W'(ring_add(int'(flush_tag), 1, DEPTH));
         count_n = CNT_W'(int'(flush_age) + 1 - n_ret);
      end else begin
         head_n  = TAG_W'(ring_add(int'(head_q), n_ret, DEPTH));
         tail_n  = TAG_W'(ring_add(int'(tail_q), int'(n_alloc), DEPTH));
         count_n = CNT_W'(int'(count_q) + int'(n_alloc) - n_ret);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         vld_q   <= '0;
         done_q  <= '0;
         exc_q   <= '0;
      end else begin
         head_q  <= head_n;
         tail_q  <= tail_n;
         count_q <= count_n;
         vld_q   <= vld_n;
         done_q  <= done_n;
         exc_q   <= exc_n;
      end
   end

   // payload storage, no reset needed
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (take_alloc[i])
            dst_q[i] <= alloc_dst[alloc_lane[i]*AREG_W +: AREG_W];
         for (int p = 0; p < CPL_N; p++) begin
            if (cpl_vld[p] && int'(cpl_tag[p*TAG_W +: TAG_W]) == i && vld_q[i])
               data_q[i] <= cpl_data[p*DATA_W +: DATA_W];
         end
      end
   end

   // ---------------- operand lookup ports ----------------
   for (genvar r = 0; r < RD_N; r++) begin : g_rd
      rob_fwd_port #(.DEPTH(DEPTH), .TAG_W(TAG_W), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_fwd (
         .head(head_q), .vld(vld_q), .done(done_q),
         .dst_flat(dst_flat), .data_flat(data_flat),
         .areg(rd_areg[r*AREG_W +: AREG_W]), .req_tag(rd_tag[r*TAG_W +: TAG_W]),
         .hit(rd_hit[r]), .ready(rd_ready[r]),
         .data(rd_data[r*DATA_W +: DATA_W]), .src(rd_src[r*TAG_W +: TAG_W])
      );
   end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
   parameter int DEPTH    = 40,
   parameter int ALLOC_W  = 3,
   parameter int COMMIT_W = 3,
   parameter int TAG_W    = 6,
   parameter int CNT_W    = 6,
   parameter int AC_W     = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic [AC_W-1:0]     alloc_cnt,
   input logic                alloc_ok,
   input logic [COMMIT_W-1:0] cmt_vld,
   input logic                exc_vld,
   input logic [CNT_W-1:0]    count,
   input logic [TAG_W-1:0]    tail,
   input logic                flush,
   input logic [TAG_W-1:0]    flush_tag
);
   // R5: commit lanes are contiguous from lane 0
   a_r5_lanes_contig: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmt_vld & (cmt_vld + 1'b1)) == '0));

   // R1: occupancy never exceeds capacity
   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(count) <= DEPTH));

   // R3: no grant when the request does not fit
   a_r3_stall_full: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(alloc_cnt) > DEPTH - int'(count)) |-> !alloc_ok);

   // R7: a flush moves the tail just past the flushing slot
   a_r7_tail_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !exc_vld) |=>
         (tail == (($past(flush_tag) == TAG_W'(DEPTH - 1)) ? '0 : $past(flush_tag) + 1'b1)));

   // R8: an exception report empties the buffer
   a_r8_exc_empties: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |=> (count == '0));

   // R8: no allocation is granted while the exception is reported
   a_r8_exc_blocks_alloc: assert property (@(posedge clk) disable iff (!rst_n)
      exc_vld |-> !alloc_ok);
endmodule

bind reorder_buf rob_checker #(
   .DEPTH(DEPTH), .ALLOC_W(ALLOC_W), .COMMIT_W(COMMIT_W),
   .TAG_W(TAG_W), .CNT_W(CNT_W), .AC_W(AC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt), .alloc_ok(alloc_ok),
   .cmt_vld(cmt_vld), .exc_vld(exc_vld), .count(count_q), .tail(tail_q),
   .flush(flush), .flush_tag(flush_tag)
);

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 40;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [1:0]  alloc_cnt = 0;
   logic [14:0] alloc_dst = 0;
   logic        alloc_ok;
   logic [5:0]  alloc_tag;
   logic [4:0]  cpl_vld = 0, cpl_exc = 0, cpl_mispred = 0;
   logic [29:0] cpl_tag = 0;
   logic [159:0] cpl_data = 0;
   logic [9:0]  rd_areg = 0;
   logic [11:0] rd_tag = 0;
   logic [1:0]  rd_hit, rd_ready;
   logic [63:0] rd_data;
   logic [11:0] rd_src;
   logic [2:0]  cmt_vld;
   logic [14:0] cmt_dst;
   logic [95:0] cmt_data;
   logic        exc_vld;
   logic [5:0]  exc_tag;

   reorder_buf uut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, failures = 0;
   int exp_tail = 0;
   int seq = 0;
   logic [31:0] tag_data [DEPTH];
   int          q_dst [$];
   logic [31:0] q_data [$];
   bit          timed_out = 0;

   task automatic chk(input string req, input longint act, input longint exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic next();
      @(posedge clk); #1;
      alloc_cnt = 0; cpl_vld = 0; cpl_exc = 0; cpl_mispred = 0;
   endtask

   task automatic cpl_set(input int p, input int tag, input bit exc, input bit mis);
      cpl_vld[p] = 1'b1;
      cpl_exc[p] = exc;
      cpl_mispred[p] = mis;
      cpl_tag[p*6 +: 6] = 6'(tag);
      cpl_data[p*32 +: 32] = tag_data[tag];
   endtask

   task automatic do_alloc(input int n, input int d0, input int d1, input int d2,
                           input bit exp_ok, input bit push, input string req);
      int dd [3];
      dd[0] = d0; dd[1] = d1; dd[2] = d2;
      next();
      alloc_cnt = 2'(n);
      alloc_dst = {5'(d2), 5'(d1), 5'(d0)};
      @(negedge clk);
      chk(req, alloc_ok, exp_ok, "alloc_ok");
      if (exp_ok) begin
         chk("R2", alloc_tag, exp_tail, "alloc_tag");
         for (int j = 0; j < n; j++) begin
            int t;
            t = (exp_tail + j) % DEPTH;
            seq++;
            tag_data[t] = 32'h100 + 32'(seq * 37);
            if (push) begin
               q_dst.push_back(dd[j]);
               q_data.push_back(tag_data[t]);
            end
         end
         exp_tail = (exp_tail + n) % DEPTH;
      end
   endtask

   task automatic lookup(input int port, input int areg, input int tag);
      rd_areg[port*5 +: 5] = 5'(areg);
      rd_tag[port*6 +: 6] = 6'(tag);
   endtask

   // scoreboard monitor: every committed lane must be the next expected item
   always @(negedge clk) begin
      if (rst_n) begin
         for (int j = 0; j < 3; j++) begin
            if (cmt_vld[j]) begin
               if (q_dst.size() == 0) begin
                  chk("R5", 1, 0, "unexpected commit");
               end else begin
                  chk("R5", cmt_dst[j*5 +: 5], q_dst.pop_front(), "commit dst");
                  chk("R5", cmt_data[j*32 +: 32], q_data.pop_front(), "commit data");
               end
            end
         end
      end
   end

   task automatic run_all();
      rst_n = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1", alloc_tag, 0, "reset alloc_tag");
      chk("R1", cmt_vld, 0, "reset cmt_vld");
      chk("R1", exc_vld, 0, "reset exc_vld");
      chk("R1", rd_hit, 0, "reset rd_hit");

      // R5: commit stops at first unfinished slot
      do_alloc(3, 1, 2, 3, 1, 1, "R2");            // tags 0,1,2
      next(); cpl_set(0, 2, 0, 0);
      next(); @(negedge clk);
      chk("R5", cmt_vld, 0, "stop at unfinished oldest");
      next(); cpl_set(0, 0, 0, 0);
      next(); @(negedge clk);
      chk("R5", cmt_vld, 3'b001, "only oldest commits");
      next(); cpl_set(0, 1, 0, 0);
      next(); @(negedge clk);
      chk("R5", cmt_vld, 3'b011, "two lanes commit");

      // R4: five completions in one cycle
      do_alloc(3, 4, 5, 6, 1, 1, "R2");            // 3,4,5
      do_alloc(3, 7, 8, 9, 1, 1, "R2");            // 6,7,8
      next();
      cpl_set(0, 8, 0, 0); cpl_set(1, 7, 0, 0); cpl_set(2, 6, 0, 0);
      cpl_set(3, 5, 0, 0); cpl_set(4, 4, 0, 0);
      next(); @(negedge clk);
      chk("R4", cmt_vld, 0, "oldest still pending");
      next(); cpl_set(0, 3, 0, 0);
      next(); @(negedge clk);
      chk("R4", cmt_vld, 3'b111, "first group of three");
      next(); @(negedge clk);
      chk("R4", cmt_vld, 3'b111, "second group of three");
      next(); @(negedge clk);
      chk("R5", cmt_vld, 0, "drained");

      // R6: operand lookup
      do_alloc(3, 5, 5, 7, 1, 1, "R2");            // 9,10,11
      do_alloc(1, 9, 0, 0, 1, 1, "R2");            // 12
      lookup(0, 5, 12); lookup(1, 5, 10);
      next(); @(negedge clk);
      chk("R6", rd_hit[0], 1, "youngest older hit");
      chk("R6", rd_src[5:0], 10, "youngest older tag");
      chk("R6", rd_ready[0], 0, "not ready yet");
      chk("R6", rd_src[11:6], 9, "older requester sees older producer");
      lookup(0, 9, 12); lookup(1, 7, 12);
      #1;
      chk("R6", rd_hit[0], 0, "own slot is not a producer");
      chk("R6", rd_src[11:6], 11, "other register producer");
      lookup(0, 5, 12);
      next(); cpl_set(0, 10, 0, 0);
      next(); @(negedge clk);
      chk("R6", rd_ready[0], 1, "ready after completion");
      chk("R6", rd_data[31:0], tag_data[10], "forwarded value");
      next(); cpl_set(0, 9, 0, 0); cpl_set(1, 11, 0, 0); cpl_set(2, 12, 0, 0);
      repeat (4) next();
      lookup(0, 5, 13);
      @(negedge clk);
      chk("R6", rd_hit[0], 0, "committed value no longer buffered");

      // R7: mispredict flush
      do_alloc(3, 1, 2, 3, 1, 1, "R2");            // 13,14,15
      do_alloc(3, 4, 5, 6, 1, 1, "R2");            // 16,17,18
      next(); cpl_set(0, 14, 0, 1);
      repeat (4) begin void'(q_dst.pop_back()); void'(q_data.pop_back()); end
      exp_tail = 15;
      next(); @(negedge clk);
      chk("R7", alloc_tag, 15, "tail after mispredict");
      do_alloc(1, 9, 0, 0, 1, 1, "R7");            // new 15
      lookup(0, 3, 16);
      next(); @(negedge clk);
      chk("R7", rd_hit[0], 0, "discarded slot not visible");
      cpl_set(0, 13, 0, 0); cpl_set(1, 15, 0, 0);
      next(); @(negedge clk);
      chk("R7", cmt_vld, 3'b111, "branch and survivors commit");

      // R9: two flushes in one cycle, oldest decides
      do_alloc(3, 1, 2, 3, 1, 1, "R2");            // 16,17,18
      do_alloc(2, 4, 5, 0, 1, 1, "R2");            // 19,20
      next(); cpl_set(0, 19, 0, 1); cpl_set(1, 17, 0, 1);
      repeat (3) begin void'(q_dst.pop_back()); void'(q_data.pop_back()); end
      exp_tail = 18;
      next(); @(negedge clk);
      chk("R9", alloc_tag, 18, "oldest flush sets tail");
      cpl_set(0, 16, 0, 0);
      next(); @(negedge clk);
      chk("R9", cmt_vld, 3'b011, "survivors commit");

      // R8: exception
      do_alloc(3, 1, 2, 3, 1, 1, "R2");            // 18,19,20
      do_alloc(1, 4, 0, 0, 1, 1, "R2");            // 21
      next(); cpl_set(0, 19, 1, 0);
      repeat (3) begin void'(q_dst.pop_back()); void'(q_data.pop_back()); end
      exp_tail = 20;
      do_alloc(1, 4, 0, 0, 1, 0, "R8");            // new 20, dropped later
      next(); cpl_set(0, 18, 0, 0);
      next(); alloc_cnt = 3;
      @(negedge clk);
      chk("R8", exc_vld, 1, "exception reported");
      chk("R8", exc_tag, 19, "exception tag");
      chk("R8", cmt_vld, 3'b001, "older slot commits, faulting not");
      chk("R3", alloc_ok, 0, "no grant during exception report");
      exp_tail = 20;
      lookup(0, 4, 20);
      next(); @(negedge clk);
      chk("R8", exc_vld, 0, "report is one cycle");
      chk("R8", alloc_tag, 20, "buffer emptied past faulting slot");
      chk("R8", rd_hit[0], 0, "younger slot discarded");

      // R3 and R1: fill and wrap
      for (int c = 0; c < 13; c++)
         do_alloc(3, c % 32, (c + 1) % 32, (c + 2) % 32, 1, 1, "R3");
      do_alloc(3, 1, 1, 1, 0, 1, "R3");
      do_alloc(1, 30, 0, 0, 1, 1, "R3");
      chk("R1", exp_tail, 20, "wrapped tail model");
      do_alloc(1, 1, 0, 0, 0, 1, "R3");
      next(); @(negedge clk);
      chk("R1", alloc_tag, 20, "full ring tail");
      for (int c = 0; c < 8; c++) begin
         next();
         for (int p = 0; p < 5; p++) cpl_set(p, (20 + c * 5 + p) % DEPTH, 0, 0);
      end
      repeat (20) next();
      @(negedge clk);
      chk("R5", q_dst.size(), 0, "all expected commits seen");
      do_alloc(3, 1, 2, 3, 1, 1, "R3");
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1;
         end
      join_any
      if (timed_out) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=1 expected=0");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule